// File: doc/BRIEF.md
# Lockable Pad Input/Output Multiplexer

This block sits between a group of on-chip peripherals and the muxed IO pads of a chip. Every peripheral input has a select register. That register either ties the input to a constant or connects it to one pad. Every pad has its own select register. That register drives the pad with a constant, releases it to high impedance, or hands it to one peripheral output together with that peripheral's output enable. Because each pad also has an output enable, a released pad is not driven at all.

Software programs the selects through a small register port with an address, write data and a write strobe. Reads are combinational. A single sticky enable bit guards every select register. Once software clears this bit, the whole routing is frozen until the next reset, so it cannot be changed later by accident or on purpose. The low select codes are reserved for constants and high-Z. The real indices start above them.

Top module: `pad_route`

## Requirements
- R1: An input select of 0 drives the peripheral input with 0, and a select of 1 drives it with 1, whatever the pads carry.
- R2: An input select of s >= 2 connects the peripheral input to pad s-2 when s-2 is below the pad count.
- R3: A pad select of 0 or 1 drives that constant on the pad, with its output enable high.
- R4: A pad select of 2 leaves the pad undriven: output enable low and output value 0.
- R5: A pad select of s >= 3 connects pad value and output enable to peripheral output s-3 when s-3 is below the peripheral output count.
- R6: A select that points past the last pad (input side) or past the last peripheral output (pad side) yields 0, and on the pad side an output enable of 0.
- R7: After reset, all input selects read 0, all pad selects read 2, and the enable bit reads 1.
- R8: The address is split into a region in its top two bits (0 = enable bit at index 0, 1 = input selects, 2 = pad selects) and an index below them. A write lands on the clock edge where the strobe is sampled. Reads return the stored value. Indices with no register, and region 3, read 0 and take no writes.
- R9: Writing 0 to bit 0 of the enable register clears it. Writing 1 never sets it again before reset.
- R10: While the enable bit is 0, writes to select registers are dropped. Reads and the routing keep the stored values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | AddrW | Register address: region in the top two bits, index below |
| regWdata | input | SelW | Write data |
| regWe | input | 1 | Write strobe |
| regRdata | output | SelW | Read data for regAddr, combinational |
| padIn | input | NumPads | Values seen at the pads |
| periphIn | output | NumPerIn | Values handed to peripheral inputs |
| periphOut | input | NumPerOut | Peripheral output values |
| periphOe | input | NumPerOut | Peripheral output enables |
| padOut | output | NumPads | Values driven to the pads |
| padOe | output | NumPads | Pad output enables |

## Verification
The assertions take for granted that the pad and peripheral inputs are steady at the sampling edge. They also assume that the write strobe is the only way the select registers change. The bench changes every input at the falling edge only, so the combinational routing has settled before the next rising edge. The bench uses a small configuration whose select codes cover the full encoding space. This way every select value, including those past the valid range, is swept on every port.

// File: rtl/pad_route_pkg.sv
package pad_route_pkg;

  typedef enum logic [1:0] {
    RegionLock = 2'd0,
    RegionIn   = 2'd1,
    RegionOut  = 2'd2,
    RegionNone = 2'd3
  } region_e;

  typedef struct packed {
    logic inWr;
    logic outWr;
  } selStrobe_t;

endpackage

// File: rtl/pad_route_ctrl.sv
module pad_route_ctrl
  import pad_route_pkg::*;
#(
  parameter int NumPerIn = 32,
  parameter int NumPads  = 32,
  parameter int SelW     = 6,
  parameter int IdxW     = 5
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [IdxW+1:0]                  regAddr,
  input  logic [SelW-1:0]                  regWdata,
  input  logic                             regWe,
  input  logic [NumPerIn-1:0][SelW-1:0]    inSel,
  input  logic [NumPads-1:0][SelW-1:0]     outSel,
  output selStrobe_t                       strobe,
  output logic [IdxW-1:0]                  wrIdx,
  output logic                             regOpen,
  output logic [SelW-1:0]                  regRdata
);
  localparam int Span = 2 ** IdxW;
  localparam logic [IdxW:0] InLimit  = (IdxW + 1)'(NumPerIn);
  localparam logic [IdxW:0] PadLimit = (IdxW + 1)'(NumPads);

  region_e region;
  logic [Span-1:0][SelW-1:0] inSelWide;
  logic [Span-1:0][SelW-1:0] outSelWide;

  assign region = region_e'(regAddr[IdxW+1:IdxW]);
  assign wrIdx  = regAddr[IdxW-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regOpen <= 1'b1;
    end else if (regWe && region == RegionLock && wrIdx == '0 && !regWdata[0]) begin
      regOpen <= 1'b0;
    end
  end

  always_comb begin
    strobe.inWr  = regWe && regOpen && region == RegionIn  && ({1'b0, wrIdx} < InLimit);
    strobe.outWr = regWe && regOpen && region == RegionOut && ({1'b0, wrIdx} < PadLimit);
  end

  always_comb begin
    inSelWide  = '0;
    outSelWide = '0;
    inSelWide[NumPerIn-1:0] = inSel;
    outSelWide[NumPads-1:0] = outSel;
  end

  always_comb begin
    regRdata = '0;
    unique case (region)
      RegionLock: regRdata = (wrIdx == '0) ? {{(SelW-1){1'b0}}, regOpen} : '0;
      RegionIn:   regRdata = inSelWide[wrIdx];
      RegionOut:  regRdata = outSelWide[wrIdx];
      default:    regRdata = '0;
    endcase
  end

endmodule

// File: rtl/pad_route_dp.sv
module pad_route_dp
  import pad_route_pkg::*;
#(
  parameter int NumPerIn  = 32,
  parameter int NumPerOut = 32,
  parameter int NumPads   = 32,
  parameter int SelW      = 6,
  parameter int IdxW      = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  selStrobe_t                    strobe,
  input  logic [IdxW-1:0]               wrIdx,
  input  logic [SelW-1:0]               wrData,
  input  logic [NumPads-1:0]            padIn,
  input  logic [NumPerOut-1:0]          periphOut,
  input  logic [NumPerOut-1:0]          periphOe,
  output logic [NumPerIn-1:0]           periphIn,
  output logic [NumPads-1:0]            padOut,
  output logic [NumPads-1:0]            padOe,
  output logic [NumPerIn-1:0][SelW-1:0] inSel,
  output logic [NumPads-1:0][SelW-1:0]  outSel
);
  localparam int SelSpan = 2 ** SelW;
  localparam logic [SelW-1:0] CodeHiZ   = SelW'(2);
  localparam logic [SelW-1:0] InBase    = SelW'(2);
  localparam logic [SelW-1:0] OutBase   = SelW'(3);

  logic [SelSpan-1:0] padWide;
  logic [SelSpan-1:0] perOutWide;
  logic [SelSpan-1:0] perOeWide;

  always_comb begin
    padWide    = '0;
    perOutWide = '0;
    perOeWide  = '0;
    padWide[NumPads-1:0]      = padIn;
    perOutWide[NumPerOut-1:0] = periphOut;
    perOeWide[NumPerOut-1:0]  = periphOe;
  end

  for (genvar i = 0; i < NumPerIn; i++) begin : gInput
    logic [SelW-1:0] offset;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        inSel[i] <= '0;
      end else if (strobe.inWr && wrIdx == IdxW'(i)) begin
        inSel[i] <= wrData;
      end
    end

    assign offset = inSel[i] - InBase;

    always_comb begin
      if (inSel[i] < InBase) periphIn[i] = inSel[i][0];
      else                   periphIn[i] = padWide[offset];
    end
  end

  for (genvar j = 0; j < NumPads; j++) begin : gPad
    logic [SelW-1:0] offset;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        outSel[j] <= CodeHiZ;
      end else if (strobe.outWr && wrIdx == IdxW'(j)) begin
        outSel[j] <= wrData;
      end
    end

    assign offset = outSel[j] - OutBase;

    always_comb begin
      if (outSel[j] < CodeHiZ) begin
        padOut[j] = outSel[j][0];
        padOe[j]  = 1'b1;
      end else if (outSel[j] == CodeHiZ) begin
        padOut[j] = 1'b0;
        padOe[j]  = 1'b0;
      end else begin
        padOut[j] = perOutWide[offset];
        padOe[j]  = perOeWide[offset];
      end
    end
  end

endmodule

// File: rtl/pad_route.sv
module pad_route
  import pad_route_pkg::*;
#(
  parameter int NumPerIn  = 32,
  parameter int NumPerOut = 32,
  parameter int NumPads   = 32,
  parameter int SelW      = 6,
  localparam int MaxCount = (NumPerIn > NumPads) ? NumPerIn : NumPads,
  localparam int IdxW     = (MaxCount > 2) ? $clog2(MaxCount) : 1,
  localparam int AddrW    = IdxW + 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [AddrW-1:0]     regAddr,
  input  logic [SelW-1:0]      regWdata,
  input  logic                 regWe,
  output logic [SelW-1:0]      regRdata,
  input  logic [NumPads-1:0]   padIn,
  output logic [NumPerIn-1:0]  periphIn,
  input  logic [NumPerOut-1:0] periphOut,
  input  logic [NumPerOut-1:0] periphOe,
  output logic [NumPads-1:0]   padOut,
  output logic [NumPads-1:0]   padOe
);
  selStrobe_t                    strobe;
  logic [IdxW-1:0]               wrIdx;
  logic                          regOpen;
  logic [NumPerIn-1:0][SelW-1:0] inSel;
  logic [NumPads-1:0][SelW-1:0]  outSel;

  pad_route_ctrl #(
    .NumPerIn(NumPerIn), .NumPads(NumPads), .SelW(SelW), .IdxW(IdxW)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWdata(regWdata), .regWe(regWe),
    .inSel(inSel), .outSel(outSel), .strobe(strobe), .wrIdx(wrIdx),
    .regOpen(regOpen), .regRdata(regRdata)
  );

  pad_route_dp #(
    .NumPerIn(NumPerIn), .NumPerOut(NumPerOut), .NumPads(NumPads), .SelW(SelW), .IdxW(IdxW)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrIdx(wrIdx), .wrData(regWdata),
    .padIn(padIn), .periphOut(periphOut), .periphOe(periphOe),
    .periphIn(periphIn), .padOut(padOut), .padOe(padOe),
    .inSel(inSel), .outSel(outSel)
  );

endmodule

// File: rtl/pad_route_chk.sv
module pad_route_chk #(
  parameter int NumPerIn = 32,
  parameter int NumPads  = 32,
  parameter int SelW     = 6
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          regWe,
  input logic                          regOpen,
  input logic [NumPerIn-1:0][SelW-1:0] inSel,
  input logic [NumPads-1:0][SelW-1:0]  outSel,
  input logic [NumPerIn-1:0]           periphIn,
  input logic [NumPads-1:0]            padOut,
  input logic [NumPads-1:0]            padOe
);

  a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !regOpen |=> !regOpen);

  a_r10_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !regOpen |=> ($stable(inSel) && $stable(outSel)));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !regWe |=> ($stable(inSel) && $stable(outSel)));

  for (genvar i = 0; i < NumPerIn; i++) begin : gInChk
    a_r1_tie_in: assert property (@(posedge clk) disable iff (!rstN)
      (inSel[i] < SelW'(2)) |-> (periphIn[i] == inSel[i][0]));
  end

  for (genvar j = 0; j < NumPads; j++) begin : gPadChk
    a_r3_tie_pad: assert property (@(posedge clk) disable iff (!rstN)
      (outSel[j] < SelW'(2)) |-> (padOe[j] && padOut[j] == outSel[j][0]));
    a_r4_release: assert property (@(posedge clk) disable iff (!rstN)
      (outSel[j] == SelW'(2)) |-> (!padOe[j] && !padOut[j]));
  end

endmodule

bind pad_route pad_route_chk #(
  .NumPerIn(NumPerIn), .NumPads(NumPads), .SelW(SelW)
) uChk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regOpen(regOpen),
  .inSel(inSel), .outSel(outSel), .periphIn(periphIn),
  .padOut(padOut), .padOe(padOe)
);

// File: tb/sim_pad_route.sv
`timescale 1ns/1ps
module sim_pad_route;
  localparam int NI = 4;
  localparam int NO = 4;
  localparam int NP = 5;
  localparam int SW = 4;
  localparam int IW = 3;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [SW-1:0] regWdata = '0;
  logic          regWe = 1'b0;
  logic [SW-1:0] regRdata;
  logic [NP-1:0] padIn = '0;
  logic [NI-1:0] periphIn;
  logic [NO-1:0] periphOut = '0;
  logic [NO-1:0] periphOe = '0;
  logic [NP-1:0] padOut;
  logic [NP-1:0] padOe;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  pad_route #(.NumPerIn(NI), .NumPerOut(NO), .NumPads(NP), .SelW(SW)) u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWdata(regWdata), .regWe(regWe),
    .regRdata(regRdata), .padIn(padIn), .periphIn(periphIn), .periphOut(periphOut),
    .periphOe(periphOe), .padOut(padOut), .padOe(padOe)
  );

  always #10 clk = ~clk;

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int region, int idx, int val);
    @(negedge clk);
    regAddr  = AW'((region << IW) | idx);
    regWdata = SW'(val);
    regWe    = 1'b1;
    @(negedge clk);
    regWe    = 1'b0;
  endtask

  task automatic rd(int region, int idx, output int val);
    regAddr = AW'((region << IW) | idx);
    #1;
    val = int'(regRdata);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R7 reset state
    for (int i = 0; i < NI; i++) begin rd(1, i, v); check("R7 insel", v, 0); end
    for (int j = 0; j < NP; j++) begin rd(2, j, v); check("R7 padsel", v, 2); end
    rd(0, 0, v); check("R7 enable", v, 1);
    padIn = '1; periphOut = '1; periphOe = '1; #1;
    check("R7 periphIn", int'(periphIn), 0);
    check("R7 padOe", int'(padOe), 0);

    // input select sweep: R1 R2 R6 R8
    for (int i = 0; i < NI; i++) begin
      for (int s = 0; s < 2 ** SW; s++) begin
        wr(1, i, s);
        rd(1, i, v); check("R8 insel readback", v, s);
        for (int p = 0; p < 2; p++) begin
          int expV;
          padIn = (p == 0) ? 5'b10110 : 5'b01001;
          #1;
          if (s < 2) expV = s;
          else if (s - 2 < NP) expV = int'(padIn[s-2]);
          else expV = 0;
          check((s < 2) ? "R1" : ((s - 2 < NP) ? "R2" : "R6"), int'(periphIn[i]), expV);
        end
      end
    end

    // pad select sweep: R3 R4 R5 R6
    for (int j = 0; j < NP; j++) begin
      for (int s = 0; s < 2 ** SW; s++) begin
        wr(2, j, s);
        rd(2, j, v); check("R8 padsel readback", v, s);
        for (int p = 0; p < 2; p++) begin
          int eo, ee;
          periphOut = (p == 0) ? 4'b1010 : 4'b0101;
          periphOe  = (p == 0) ? 4'b0110 : 4'b1100;
          #1;
          if (s < 2) begin eo = s; ee = 1; end
          else if (s == 2) begin eo = 0; ee = 0; end
          else if (s - 3 < NO) begin eo = int'(periphOut[s-3]); ee = int'(periphOe[s-3]); end
          else begin eo = 0; ee = 0; end
          check((s < 2) ? "R3 out" : (s == 2) ? "R4 out" : (s - 3 < NO) ? "R5 out" : "R6 out",
                int'(padOut[j]), eo);
          check((s < 2) ? "R3 oe" : (s == 2) ? "R4 oe" : (s - 3 < NO) ? "R5 oe" : "R6 oe",
                int'(padOe[j]), ee);
        end
      end
    end

    // R8 unused indices and region
    wr(1, 5, 7); rd(1, 5, v); check("R8 unused in idx", v, 0);
    wr(2, 6, 7); rd(2, 6, v); check("R8 unused pad idx", v, 0);
    wr(3, 1, 7); rd(3, 1, v); check("R8 region3", v, 0);

    // R9 / R10 lock
    wr(0, 0, 1); rd(0, 0, v); check("R9 write one keeps", v, 1);
    wr(1, 0, 3); rd(1, 0, v); check("R8 insel before lock", v, 3);
    wr(2, 0, 0); rd(2, 0, v); check("R8 padsel before lock", v, 0);
    wr(0, 0, 0); rd(0, 0, v); check("R9 cleared", v, 0);
    wr(1, 0, 6); rd(1, 0, v); check("R10 insel frozen", v, 3);
    padIn = 5'b00010; #1; check("R10 route kept", int'(periphIn[0]), 1);
    padIn = 5'b11101; #1; check("R10 route kept", int'(periphIn[0]), 0);
    wr(2, 0, 1); rd(2, 0, v); check("R10 padsel frozen", v, 0);
    check("R10 pad value", int'(padOut[0]), 0);
    check("R10 pad oe", int'(padOe[0]), 1);
    wr(0, 0, 1); rd(0, 0, v); check("R9 sticky", v, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule